// File: doc/BRIEF.md
# Multi-Slot Entry Match Resolver

This block settles one lookup against a single hash-table entry that holds several slots, each carrying a key, a value and a valid flag. All slots are compared against the query key in the same cycle. A search gets back a hit flag, the matching slot number and its value. An insert gets one of three results:

- a slot to write into, when the key is new and a slot is free;
- a refusal, when the key is already present;
- an entry-full indication, when the key is new and every slot is taken.

The caller reads the entry from memory and presents the slot contents together with the query. One clock later it receives a registered result. The chosen slot number travels on to whatever performs the write. A new query can be presented on every clock.

Top module: `slot_resolver`

## Requirements
- R1: While reset is high and on the first cycle after it, every output is 0.
- R2: A slot counts as a match only when its valid bit is 1 and its stored key equals the query key; an equal key in an invalid slot produces no hit.
- R3: On a hit, `res_hit` is 1, `res_hit_slot` gives the lowest-index matching slot and `res_hit_val` gives that slot's value. Slot i occupies bits [i*KEY_W +: KEY_W] of the key bus and [i*VAL_W +: VAL_W] of the value bus.
- R4: A search (`q_op` = 0) never sets `res_ins_ok` or `res_full`, whatever the slot contents.
- R5: An insert (`q_op` = 1) with no match and at least one invalid slot sets `res_ins_ok`, and `res_ins_slot` is the lowest-index invalid slot.
- R6: An insert whose key matches a valid slot reports `res_hit` = 1, `res_ins_ok` = 0 and `res_full` = 0, and allocates no slot.
- R7: An insert with no match and all slots valid reports `res_full` = 1 and `res_ins_ok` = 0.
- R8: Each query sampled with `q_valid` high produces `res_valid` = 1 exactly one clock later, including on back-to-back cycles.
- R9: A clock without `q_valid` produces `res_valid` = 0 with every result field 0 on the next cycle; when a field has nothing to report it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_valid | input | 1 | Query present this cycle |
| q_op | input | 1 | 0 = search, 1 = insert |
| q_key | input | KEY_W | Query key |
| ent_keys | input | NSLOT*KEY_W | Stored keys, slot i at [i*KEY_W +: KEY_W] |
| ent_vals | input | NSLOT*VAL_W | Stored values, slot i at [i*VAL_W +: VAL_W] |
| ent_valid | input | NSLOT | Valid bit per slot |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Key found in a valid slot |
| res_hit_slot | output | IDX_W | Lowest matching slot |
| res_hit_val | output | VAL_W | Value of the matching slot |
| res_ins_slot | output | IDX_W | Slot chosen for the insert |
| res_ins_ok | output | 1 | Insert may proceed |
| res_full | output | 1 | Insert failed, no free slot |

## Verification
The main function is exercised with several slot-content patterns:

- a single valid match, which separates correct indexing from a fixed slot;
- an equal key parked in an invalid slot, which separates gating by the valid bit from a bare key compare;
- two valid matches, which exposes the priority order;
- free-slot masks with gaps, such as only slot 2 free, which show whether the lowest invalid slot is chosen.

Each operation is tried against a full entry and against an entry holding the key, which tells the refusal, full and allocate outcomes apart. A run of back-to-back queries drawn from a small key pool mixes all cases. A behavioural model predicts every field one cycle later.

// File: rtl/slot_res_pkg.sv
package slot_res_pkg;

    typedef enum logic {
        OP_SEARCH = 1'b0,
        OP_INSERT = 1'b1
    } op_e;

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/slot_key_cmp.sv
module slot_key_cmp #(
    parameter int NSLOT = 4,
    parameter int KEY_W = 32
) (
    input  logic [NSLOT*KEY_W-1:0] keys,
    input  logic [NSLOT-1:0]       valid,
    input  logic [KEY_W-1:0]       probe,
    output logic [NSLOT-1:0]       match
);
    for (genvar g = 0; g < NSLOT; g++) begin : g_cmp
        assign match[g] = valid[g] && (keys[g*KEY_W +: KEY_W] == probe);
    end
endmodule

// File: rtl/low_pick.sv
module low_pick #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/slot_resolver.sv
module slot_resolver
    import slot_res_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int KEY_W = 32,
    parameter int VAL_W = 32,
    localparam int IDX_W = idx_width(NSLOT)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   q_valid,
    input  logic                   q_op,
    input  logic [KEY_W-1:0]       q_key,
    input  logic [NSLOT*KEY_W-1:0] ent_keys,
    input  logic [NSLOT*VAL_W-1:0] ent_vals,
    input  logic [NSLOT-1:0]       ent_valid,
    output logic                   res_valid,
    output logic                   res_hit,
    output logic [IDX_W-1:0]       res_hit_slot,
    output logic [VAL_W-1:0]       res_hit_val,
    output logic [IDX_W-1:0]       res_ins_slot,
    output logic                   res_ins_ok,
    output logic                   res_full
);
    typedef struct packed {
        logic             valid;
        logic             hit;
        logic [IDX_W-1:0] hit_slot;
        logic [VAL_W-1:0] hit_val;
        logic [IDX_W-1:0] ins_slot;
        logic             ins_ok;
        logic             full;
    } result_t;

    logic [NSLOT-1:0] match;
    logic [NSLOT-1:0] free_mask;
    logic             any_match, any_free;
    logic [IDX_W-1:0] match_idx, free_idx;
    op_e              op;
    result_t          nxt, cur;

    assign op        = op_e'(q_op);
    assign free_mask = ~ent_valid;

    slot_key_cmp #(.NSLOT(NSLOT), .KEY_W(KEY_W)) u_cmp (
        .keys  (ent_keys),
        .valid (ent_valid),
        .probe (q_key),
        .match (match)
    );

    low_pick #(.N(NSLOT), .IW(IDX_W)) u_hit_pick (
        .req (match),
        .any (any_match),
        .idx (match_idx)
    );

    low_pick #(.N(NSLOT), .IW(IDX_W)) u_free_pick (
        .req (free_mask),
        .any (any_free),
        .idx (free_idx)
    );

    always_comb begin
        nxt          = '0;
        nxt.valid    = 1'b1;
        nxt.hit      = any_match;
        nxt.hit_slot = any_match ? match_idx : '0;
        nxt.hit_val  = any_match ? ent_vals[int'(match_idx)*VAL_W +: VAL_W] : '0;
        if (op == OP_INSERT && !any_match) begin
            nxt.ins_ok   = any_free;
            nxt.ins_slot = any_free ? free_idx : '0;
            nxt.full     = !any_free;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
        end else if (q_valid) begin
            cur <= nxt;
        end else begin
            cur <= '0;
        end
    end

    assign res_valid    = cur.valid;
    assign res_hit      = cur.hit;
    assign res_hit_slot = cur.hit_slot;
    assign res_hit_val  = cur.hit_val;
    assign res_ins_slot = cur.ins_slot;
    assign res_ins_ok   = cur.ins_ok;
    assign res_full     = cur.full;
endmodule

// File: rtl/slot_resolver_chk.sv
module slot_resolver_chk #(
    parameter int NSLOT = 4,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             q_valid,
    input logic             q_op,
    input logic [NSLOT-1:0] ent_valid,
    input logic             res_valid,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_ins_slot,
    input logic             res_ins_ok,
    input logic             res_full
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_hit && !res_ins_ok && !res_full));

    // R8
    latency_one_chk: assert property (@(posedge clk) disable iff (rst)
        q_valid |=> res_valid);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !q_valid |=> (!res_valid && !res_hit && !res_ins_ok && !res_full));

    // R4
    search_no_alloc_chk: assert property (@(posedge clk) disable iff (rst)
        (q_valid && !q_op) |=> (!res_ins_ok && !res_full));

    // R2
    invalid_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (q_valid && ent_valid == '0) |=> !res_hit);

    // R5
    empty_insert_slot0_chk: assert property (@(posedge clk) disable iff (rst)
        (q_valid && q_op && ent_valid == '0) |=> (res_ins_ok && res_ins_slot == '0));

    // R7
    full_excl_chk: assert property (@(posedge clk) disable iff (rst)
        res_full |-> (!res_ins_ok && !res_hit));
endmodule

bind slot_resolver slot_resolver_chk #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .q_valid      (q_valid),
    .q_op         (q_op),
    .ent_valid    (ent_valid),
    .res_valid    (res_valid),
    .res_hit      (res_hit),
    .res_ins_slot (res_ins_slot),
    .res_ins_ok   (res_ins_ok),
    .res_full     (res_full)
);

// File: tb/slot_resolver_tb.sv
module slot_resolver_tb;
    localparam int NS = 4;
    localparam int KW = 32;
    localparam int VW = 32;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic q_valid = 1'b0;
    logic q_op = 1'b0;
    logic [KW-1:0] q_key = '0;
    logic [NS*KW-1:0] ent_keys = '0;
    logic [NS*VW-1:0] ent_vals = '0;
    logic [NS-1:0] ent_valid = '0;
    logic res_valid, res_hit, res_ins_ok, res_full;
    logic [IW-1:0] res_hit_slot, res_ins_slot;
    logic [VW-1:0] res_hit_val;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    slot_resolver #(.NSLOT(NS), .KEY_W(KW), .VAL_W(VW)) u_dut (
        .clk(clk), .rst(rst), .q_valid(q_valid), .q_op(q_op), .q_key(q_key),
        .ent_keys(ent_keys), .ent_vals(ent_vals), .ent_valid(ent_valid),
        .res_valid(res_valid), .res_hit(res_hit), .res_hit_slot(res_hit_slot),
        .res_hit_val(res_hit_val), .res_ins_slot(res_ins_slot),
        .res_ins_ok(res_ins_ok), .res_full(res_full)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_slot(input int i, input logic [KW-1:0] k,
                            input logic [VW-1:0] v, input logic vb);
        ent_keys[i*KW +: KW] = k;
        ent_vals[i*VW +: VW] = v;
        ent_valid[i] = vb;
    endtask

    // Drive one query at a falling edge, check one cycle later against the model.
    task automatic query(input string req, input logic op, input logic [KW-1:0] key);
        bit e_hit = 0, e_ok = 0, e_full = 0;
        int e_hs = 0, e_is = 0;
        longint e_hv = 0;
        int first_free = -1;
        q_valid = 1'b1;
        q_op = op;
        q_key = key;
        for (int i = NS - 1; i >= 0; i--) begin
            if (ent_valid[i] && ent_keys[i*KW +: KW] == key) begin
                e_hit = 1;
                e_hs = i;
                e_hv = ent_vals[i*VW +: VW];
            end
            if (!ent_valid[i]) first_free = i;
        end
        if (op && !e_hit) begin
            if (first_free >= 0) begin
                e_ok = 1;
                e_is = first_free;
            end else begin
                e_full = 1;
            end
        end
        @(negedge clk);
        check(req, "res_valid (R8)", res_valid, 1);
        check(req, "res_hit", res_hit, e_hit);
        check(req, "res_hit_slot", res_hit_slot, e_hs);
        check(req, "res_hit_val", res_hit_val, e_hv);
        check(req, "res_ins_ok", res_ins_ok, e_ok);
        check(req, "res_ins_slot", res_ins_slot, e_is);
        check(req, "res_full", res_full, e_full);
    endtask

    task automatic idle_check(input string req);
        q_valid = 1'b0;
        q_op = 1'b1;
        @(negedge clk);
        check(req, "res_valid", res_valid, 0);
        check(req, "res_hit", res_hit, 0);
        check(req, "res_hit_slot", res_hit_slot, 0);
        check(req, "res_hit_val", res_hit_val, 0);
        check(req, "res_ins_ok", res_ins_ok, 0);
        check(req, "res_ins_slot", res_ins_slot, 0);
        check(req, "res_full", res_full, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs during and just after reset
        q_valid = 1'b1;
        q_op = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "res_valid in reset", res_valid, 0);
        check("R1", "res_ins_ok in reset", res_ins_ok, 0);
        rst = 1'b0;
        q_valid = 1'b0;
        @(negedge clk);
        check("R1", "res_valid after reset", res_valid, 0);
        check("R1", "res_full after reset", res_full, 0);

        // R3: single valid match in slot 2
        set_slot(0, 32'h11, 32'hA0, 1);
        set_slot(1, 32'h22, 32'hA1, 1);
        set_slot(2, 32'h33, 32'hA2, 1);
        set_slot(3, 32'h44, 32'hA3, 0);
        query("R3", 1'b0, 32'h33);
        check("R3", "hit slot 2", res_hit_slot, 2);

        // R2: equal key in invalid slot 3 only
        set_slot(3, 32'h55, 32'hA3, 0);
        query("R2", 1'b0, 32'h55);
        check("R2", "no hit on invalid slot", res_hit, 0);

        // R3: two matches, lowest index wins
        set_slot(1, 32'h77, 32'hB1, 1);
        set_slot(3, 32'h77, 32'hB3, 1);
        query("R3", 1'b0, 32'h77);
        check("R3", "lowest match", res_hit_slot, 1);
        check("R3", "lowest match value", res_hit_val, 32'hB1);

        // R4: search miss with a free slot
        set_slot(2, 32'h33, 32'hA2, 0);
        query("R4", 1'b0, 32'h99);
        check("R4", "search never allocates", res_ins_ok, 0);

        // R5: insert with gap, only slot 2 free
        ent_valid = 4'b1011;
        query("R5", 1'b1, 32'h99);
        check("R5", "first free slot", res_ins_slot, 2);

        // R5: insert into empty entry
        ent_valid = 4'b0000;
        query("R5", 1'b1, 32'h11);
        check("R5", "empty entry slot 0", res_ins_slot, 0);

        // R6: insert with existing key
        ent_valid = 4'b0101;
        query("R6", 1'b1, 32'h33);
        check("R6", "duplicate refused", res_ins_ok, 0);
        check("R6", "duplicate hit", res_hit, 1);

        // R7: insert new key into full entry
        ent_valid = 4'b1111;
        query("R7", 1'b1, 32'hEE);
        check("R7", "entry full", res_full, 1);

        // R4: search on full entry with no match
        query("R4", 1'b0, 32'hEE);
        check("R4", "search no full flag", res_full, 0);

        // R9: idle cycle after activity
        idle_check("R9");

        // R8: back-to-back mixed queries from a small key pool
        for (int n = 0; n < 200; n++) begin
            for (int s = 0; s < NS; s++) begin
                set_slot(s, 32'($urandom_range(0, 5)), $urandom, 1'($urandom));
            end
            query("R8", 1'($urandom), 32'($urandom_range(0, 5)));
        end
        idle_check("R9");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule